// File: doc/BRIEF.md
# Epoch Undo Logger for Cache Lines

This block records undo information for cache lines so that the memory image at an earlier checkpoint can be rebuilt. Time is divided into epochs. Each checkpoint pulse ends the current epoch and starts the next one. The first accepted store to a line within an epoch appends one entry to a circular log. The entry holds the epoch number, the line index and the value the line had before that store. Later stores to the same line in that epoch add nothing. The cache supplies the old value together with the store request.

The log keeps the entries of at most four epochs. Since checkpoints come every third of a replay interval, three complete epochs always cover one full interval, while the fourth is the one being filled. When a checkpoint would open a fifth epoch, the oldest epoch's entries are released in one step by moving the ring's tail past them. If the log has no room for an entry that a store needs, the store is held off by backpressure rather than losing its entry.

Software or a replay engine inspects the log through a random-access read port, indexed from the oldest entry. Default configuration: 8 lines (3-bit index), 8-bit line data, 8 log entries, 8-bit epoch number.

Top module: `ckpt_undo_log`

## Requirements
- R1: After reset, epochNum is 0, logCount is 0, storeReady is 1 and rdValid is 0 for every rdOffset.
- R2: An accepted store to a line whose updated-flag is clear appends an entry {epoch = current epochNum, line = storeLine, data = storeOld}, and logCount rises by one on the next clock.
- R3: An accepted store to a line already logged in the current epoch adds no entry and leaves logCount and the log contents unchanged.
- R4: A cycle with ckptPulse high increments epochNum by one (modulo 256) and clears every line's updated-flag, so the next store to any line logs again.
- R5: The log holds entries of at most four epochs. A checkpoint taken while four epochs are live removes every entry of the oldest one: logCount drops by that epoch's entry count and rdOffset 0 then shows the next oldest entry.
- R6: logCount never exceeds 8, the log depth.
- R7: storeReady is low exactly when the line on storeLine has a clear flag and logCount is 8. A store offered while storeReady is low adds no entry and sets no flag. Stores to already-flagged lines stay ready when the log is full.
- R8: When a store and ckptPulse come in the same cycle, the store is handled first: its entry carries the old epoch number, and the line's flag is clear in the new epoch.
- R9: For rdOffset k below logCount, rdValid is 1 and rdEpoch/rdLine/rdData show the k-th oldest entry (k = 0 is oldest), combinationally. For k at or above logCount, rdValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| storeValid | input | 1 | Store request present this cycle |
| storeLine | input | 3 | Line index of the store |
| storeOld | input | 8 | Line contents before the store |
| storeReady | output | 1 | Store can be accepted this cycle |
| ckptPulse | input | 1 | Begin a new epoch after this cycle |
| epochNum | output | 8 | Current epoch number |
| logCount | output | 4 | Number of valid log entries |
| rdOffset | input | 3 | Read index counted from the oldest entry |
| rdValid | output | 1 | rdOffset addresses a valid entry |
| rdEpoch | output | 8 | Epoch number of the addressed entry |
| rdLine | output | 3 | Line index of the addressed entry |
| rdData | output | 8 | Old line data of the addressed entry |

## Verification
A stale updated-flag shows up as a missing or an extra entry. It is visible on logCount one clock after the store, and through the read port in the same cycle. A wrong per-epoch entry count or a misplaced tail pointer only surfaces when the fourth live epoch is retired. At that checkpoint, logCount and the entry at offset 0 show the error at once. So the sweep runs through many epochs, with retirements both on a full log and on a partly filled one. A wrong stall decision shows on storeReady in the same cycle the store is offered.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  localparam int LINE_W      = 3;
  localparam int DATA_W      = 8;
  localparam int LOG_DEPTH   = 8;   // power of two
  localparam int EPOCH_W     = 8;
  localparam int RING_EPOCHS = 4;   // power of two

  localparam int NUM_LINES = 1 << LINE_W;
  localparam int PTR_W     = $clog2(LOG_DEPTH);
  localparam int CNT_W     = $clog2(LOG_DEPTH + 1);
  localparam int SLOT_W    = $clog2(RING_EPOCHS);
  localparam int LIVE_W    = $clog2(RING_EPOCHS + 1);

  typedef struct packed {
    logic               push;
    logic [EPOCH_W-1:0] pushEpoch;
    logic               drop;
    logic [CNT_W-1:0]   dropCount;
  } logStrobe_t;

  typedef struct packed {
    logic [EPOCH_W-1:0] epoch;
    logic [LINE_W-1:0]  line;
    logic [DATA_W-1:0]  data;
  } logEntry_t;
endpackage

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
  import ckpt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               storeValid,
  input  logic [LINE_W-1:0]  storeLine,
  input  logic               ckptPulse,
  output logic               storeReady,
  output logic [EPOCH_W-1:0] epochNum,
  output logic [CNT_W-1:0]   logCount,
  output logStrobe_t         strobe
);
  logic [NUM_LINES-1:0] flagBits;
  logic [LIVE_W-1:0]    liveEpochs;
  logic [CNT_W-1:0]     epochCnt [RING_EPOCHS];
  logic [SLOT_W-1:0]    curSlot;
  logic [SLOT_W-1:0]    nextSlot;
  logic                 lineDirty;
  logic                 logFull;
  logic                 pushNow;
  logic                 dropNow;
  logic [CNT_W-1:0]     dropAmt;

  always_comb begin
    curSlot    = epochNum[SLOT_W-1:0];
    nextSlot   = curSlot + SLOT_W'(1);
    lineDirty  = flagBits[storeLine];
    logFull    = (logCount == CNT_W'(LOG_DEPTH));
    storeReady = lineDirty || !logFull;
    pushNow    = storeValid && !lineDirty && !logFull;
    dropNow    = ckptPulse && (liveEpochs == LIVE_W'(RING_EPOCHS));
    dropAmt    = dropNow ? epochCnt[nextSlot] : '0;
    strobe.push      = pushNow;
    strobe.pushEpoch = epochNum;
    strobe.drop      = dropNow;
    strobe.dropCount = dropAmt;
  end

  // one entry counter per epoch slot in the ring
  for (genvar g = 0; g < RING_EPOCHS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        epochCnt[g] <= '0;
      else if (ckptPulse && nextSlot == SLOT_W'(g))
        epochCnt[g] <= '0;
      else if (pushNow && curSlot == SLOT_W'(g))
        epochCnt[g] <= epochCnt[g] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epochNum   <= '0;
      liveEpochs <= LIVE_W'(1);
      logCount   <= '0;
      flagBits   <= '0;
    end else begin
      logCount <= logCount + CNT_W'(pushNow) - dropAmt;
      if (ckptPulse) begin
        epochNum <= epochNum + EPOCH_W'(1);
        flagBits <= '0;
        if (liveEpochs != LIVE_W'(RING_EPOCHS))
          liveEpochs <= liveEpochs + LIVE_W'(1);
      end else if (pushNow) begin
        flagBits[storeLine] <= 1'b1;
      end
    end
  end

  // R6: occupancy bound
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    logCount <= CNT_W'(LOG_DEPTH));

  // R7: a stall only ever happens on a full log
  a_r7_stall_only_full: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && !storeReady) |-> (logCount == CNT_W'(LOG_DEPTH)));

  // R2: an accepted store leaves its line flagged in the same epoch
  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (storeValid && storeReady && !ckptPulse) |=> flagBits[$past(storeLine)]);

  // R4: checkpoint advances epoch and clears all flags
  a_r4_epoch_step: assert property (@(posedge clk) disable iff (!rstN)
    ckptPulse |=> (epochNum == $past(epochNum) + EPOCH_W'(1)) && (flagBits == '0));

  // R5: between one and four live epochs
  a_r5_live_bound: assert property (@(posedge clk) disable iff (!rstN)
    (liveEpochs != '0) && (liveEpochs <= LIVE_W'(RING_EPOCHS)));
endmodule

// File: rtl/ckpt_logstore.sv
module ckpt_logstore
  import ckpt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logStrobe_t         strobe,
  input  logic [LINE_W-1:0]  storeLine,
  input  logic [DATA_W-1:0]  storeOld,
  input  logic [CNT_W-1:0]   logCount,
  input  logic [PTR_W-1:0]   rdOffset,
  output logic               rdValid,
  output logic [EPOCH_W-1:0] rdEpoch,
  output logic [LINE_W-1:0]  rdLine,
  output logic [DATA_W-1:0]  rdData
);
  logEntry_t        ringMem [LOG_DEPTH];
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [PTR_W-1:0] rdIdx;
  logEntry_t        rdEntry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobe.push)
        headPtr <= headPtr + PTR_W'(1);
      if (strobe.drop)
        tailPtr <= tailPtr + PTR_W'(strobe.dropCount);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push)
      ringMem[headPtr] <= '{epoch: strobe.pushEpoch, line: storeLine, data: storeOld};
  end

  always_comb begin
    rdIdx   = tailPtr + rdOffset;
    rdEntry = ringMem[rdIdx];
    rdValid = CNT_W'(rdOffset) < logCount;
    rdEpoch = rdEntry.epoch;
    rdLine  = rdEntry.line;
    rdData  = rdEntry.data;
  end

  // R9: pointer gap agrees with the control's occupancy
  a_r9_ptr_gap: assert property (@(posedge clk) disable iff (!rstN)
    (headPtr - tailPtr) == PTR_W'(logCount));

  // R5: tail moves only on an epoch retirement
  a_r5_tail_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.drop) |-> $stable(tailPtr));
endmodule

// File: rtl/ckpt_undo_log.sv
module ckpt_undo_log
  import ckpt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               storeValid,
  input  logic [LINE_W-1:0]  storeLine,
  input  logic [DATA_W-1:0]  storeOld,
  output logic               storeReady,
  input  logic               ckptPulse,
  output logic [EPOCH_W-1:0] epochNum,
  output logic [CNT_W-1:0]   logCount,
  input  logic [PTR_W-1:0]   rdOffset,
  output logic               rdValid,
  output logic [EPOCH_W-1:0] rdEpoch,
  output logic [LINE_W-1:0]  rdLine,
  output logic [DATA_W-1:0]  rdData
);
  logStrobe_t strobe;

  ckpt_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .storeValid (storeValid),
    .storeLine  (storeLine),
    .ckptPulse  (ckptPulse),
    .storeReady (storeReady),
    .epochNum   (epochNum),
    .logCount   (logCount),
    .strobe     (strobe)
  );

  ckpt_logstore uStore (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .storeLine (storeLine),
    .storeOld  (storeOld),
    .logCount  (logCount),
    .rdOffset  (rdOffset),
    .rdValid   (rdValid),
    .rdEpoch   (rdEpoch),
    .rdLine    (rdLine),
    .rdData    (rdData)
  );
endmodule

// File: tb/tb_ckpt_undo_log.sv
`timescale 1ns/1ps
module tb_ckpt_undo_log;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       storeValid = 1'b0;
  logic [2:0] storeLine = '0;
  logic [7:0] storeOld = '0;
  logic       storeReady;
  logic       ckptPulse = 1'b0;
  logic [7:0] epochNum;
  logic [3:0] logCount;
  logic [2:0] rdOffset = '0;
  logic       rdValid;
  logic [7:0] rdEpoch;
  logic [2:0] rdLine;
  logic [7:0] rdData;

  int checks = 0;
  int fails  = 0;

  // bench reference state
  int mEpoch = 0;
  int mLive  = 1;
  int mCnt [4];
  bit mFlag [8];
  int qEp [$];
  int qLn [$];
  int qDt [$];

  ckpt_undo_log dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic dumpLog(input string req);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rdOffset = 3'(k);
      #1;
      chk(rdValid == (k < qEp.size()), req, int'(rdValid), int'(k < qEp.size()));
      if (k < qEp.size()) begin
        chk(rdEpoch == 8'(qEp[k]), req, rdEpoch, qEp[k]);
        chk(rdLine  == 3'(qLn[k]), req, rdLine, qLn[k]);
        chk(rdData  == 8'(qDt[k]), req, rdData, qDt[k]);
      end
    end
  endtask

  // one cycle of stimulus: optional store, optional checkpoint
  task automatic step(input bit doSt, input int ln, input int dt, input bit doCk);
    bit expReady;
    bit willPush;
    int oldCnt;
    @(negedge clk);
    storeValid = doSt;
    storeLine  = 3'(ln);
    storeOld   = 8'(dt);
    ckptPulse  = doCk;
    expReady   = mFlag[ln] || (qEp.size() < 8);
    willPush   = doSt && !mFlag[ln] && (qEp.size() < 8);
    oldCnt     = qEp.size();
    #1;
    if (doSt) chk(storeReady == expReady, "R7", storeReady, expReady);
    @(negedge clk);
    storeValid = 1'b0;
    ckptPulse  = 1'b0;
    if (willPush) begin
      qEp.push_back(mEpoch % 256);
      qLn.push_back(ln);
      qDt.push_back(dt);
      mFlag[ln] = 1'b1;
      mCnt[mEpoch % 4]++;
    end
    if (doCk) begin
      if (mLive == 4) begin
        for (int i = 0; i < mCnt[(mEpoch + 1) % 4]; i++) begin
          void'(qEp.pop_front());
          void'(qLn.pop_front());
          void'(qDt.pop_front());
        end
      end else begin
        mLive++;
      end
      mCnt[(mEpoch + 1) % 4] = 0;
      mEpoch++;
      foreach (mFlag[i]) mFlag[i] = 1'b0;
    end
    #1;
    if (doSt && !willPush && !doCk)
      chk(logCount == 4'(oldCnt), "R3", logCount, oldCnt);
    else if (willPush && !doCk)
      chk(logCount == 4'(oldCnt + 1), "R2", logCount, oldCnt + 1);
    chk(logCount == 4'(qEp.size()), doCk ? "R5" : "R2", logCount, qEp.size());
    chk(logCount <= 4'd8, "R6", logCount, 8);
    chk(epochNum == 8'(mEpoch % 256), "R4", epochNum, mEpoch % 256);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    foreach (mCnt[i]) mCnt[i] = 0;
    foreach (mFlag[i]) mFlag[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(epochNum == 8'd0, "R1", epochNum, 0);
    chk(logCount == 4'd0, "R1", logCount, 0);
    chk(storeReady == 1'b1, "R1", storeReady, 1);
    dumpLog("R1");

    // epoch 0: five first stores, then a repeat (R2, R3)
    for (int l = 0; l < 5; l++) step(1, l, 8'h10 + l, 0);
    step(1, 2, 8'hEE, 0);
    dumpLog("R2");

    // epoch 1: flags cleared, line 2 logs again (R4)
    step(0, 0, 0, 1);
    step(1, 2, 8'h22, 0);
    chk(logCount == 4'd6, "R4", logCount, 6);
    step(1, 5, 8'h25, 0);
    step(1, 6, 8'h26, 0);
    // log full: new line stalls, flagged line stays ready (R7)
    step(1, 7, 8'h27, 0);
    chk(logCount == 4'd8, "R7", logCount, 8);
    step(1, 5, 8'h99, 0);
    step(0, 0, 0, 1);   // epoch 2
    step(1, 0, 8'h30, 0);
    step(0, 0, 0, 1);   // epoch 3, four live
    step(1, 1, 8'h31, 0);
    step(0, 0, 0, 1);   // epoch 4 retires epoch 0 (R5)
    chk(logCount == 4'd3, "R5", logCount, 3);
    dumpLog("R5");

    // store and checkpoint together (R8)
    step(1, 1, 8'h41, 1);
    chk(epochNum == 8'd5, "R8", epochNum, 5);
    step(1, 1, 8'h51, 0);
    dumpLog("R8");

    // sweep over many epochs with varied store patterns
    for (int e = 0; e < 40; e++) begin
      for (int l = 0; l < 8; l++)
        if (((l * 3 + e) % 5) < 2 + (e % 3)) step(1, l, (e * 16 + l) & 255, 0);
      step(1, e % 8, (e * 7) & 255, 0);
      step(1, (e + 3) % 8, (e * 5 + 1) & 255, (e % 3) == 0);
      if ((e % 3) != 0) step(0, 0, 0, 1);
      dumpLog("R9");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule